// File: doc/BRIEF.md
# Two-Channel I/O Flag and Control Handshake

This block holds the handshake state a host processor sees on a peripheral card that answers on two adjacent I/O addresses: a command channel and a data channel. Each channel keeps a flag, a flag buffer and a service-request output. The command channel also keeps a control bit, which together with its flag forms an interrupt request. The host drives one I/O operation per strobe, names the channel it addresses, and may add a hold/clear modifier that clears the addressed flag once the operation is done. Skip tests return a combinational skip signal in the same cycle.

The data channel adds an 8-bit holding register that the host can write, load or merge into its accumulator, and a data-transfer flip-flop. Other blocks start a transfer through a start strobe, and the host ends it with a control-clear or a reset on the data channel. Tape motion and command decoding sit elsewhere. They reach the flags only through per-channel set and clear strobes.

Each channel is a four-state machine over {control, flag}:
- `ST_IDLE`: control 0, flag 0.
- `ST_FLAGGED`: control 0, flag 1.
- `ST_ARMED`: control 1, flag 0.
- `ST_REQUEST`: control 1, flag 1. This state raises the interrupt request.

The transitions are:
- **flag-set**: IDLE→FLAGGED, ARMED→REQUEST.
- **flag-clear**: the reverse of flag-set.
- **control-set**: IDLE→ARMED, FLAGGED→REQUEST.
- **control-clear**: the reverse of control-set.

Flag and control transitions can happen in the same cycle. The data channel has no control-set transition, so it stays in `ST_IDLE` and `ST_FLAGGED`.

Top module: `iochan_flag_ctrl`

## Requirements
- R1: After reset, on both channels, flag, flag buffer, service request, control and interrupt request are 0. The transfer flip-flop is 0 and the holding register reads 0.
- R2: When `io_strobe` is high with `io_op`=1 (set flag) and `io_hold_clr`=0, the addressed channel's flag and flag buffer are 1 after the clock edge. `io_sel`=0 addresses the command channel and `io_sel`=1 the data channel. The other channel is unchanged.
- R3: Set flag with `io_hold_clr`=1 does not set the flag. Any operation carrying `io_hold_clr`=1 leaves the addressed channel's flag and flag buffer at 0 after the edge.
- R4: `skip` is combinational and valid while `io_strobe` is high. With `io_op`=2 it is 1 when the addressed flag is 0. With `io_op`=3 it is 1 when the addressed flag is 1. Otherwise it is 0.
- R5: Each service request output equals its channel's flag. `cmd_irq` is 1 exactly when the command flag and `cmd_ctl` are both 1.
- R6: On the command channel, a control operation (`io_op`=7) or a reset operation (`io_op`=0) clears `cmd_ctl` when `io_ctl_clr`=1 and sets it when `io_ctl_clr`=0.
- R7: On the data channel, control with `io_ctl_clr`=1, or reset regardless of `io_ctl_clr`, clears `xfer_active`. Control with `io_ctl_clr`=0 leaves it unchanged.
- R8: On the data channel, `io_op`=4 stores `io_bus_in[7:0]` in the holding register. `io_op`=6 returns the register zero-extended on `io_bus_out`. `io_op`=5 returns `io_bus_in` ORed with the register.
- R9: `*_flag_set` and `*_flag_clr` strobes set or clear that channel's flag and flag buffer at the next edge. A clear wins over any set in the same cycle.
- R10: `xfer_start` sets `xfer_active` at the next edge. A data-channel clear in the same cycle wins.
- R11: For every operation other than load or merge on the data channel, `io_bus_out` equals `io_bus_in`. Output on the command channel does not change the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_strobe | input | 1 | Host I/O operation valid this cycle |
| io_sel | input | 1 | Addressed channel: 0 command, 1 data |
| io_op | input | 3 | 0 reset, 1 set flag, 2 skip-if-clear, 3 skip-if-set, 4 output, 5 merge, 6 load, 7 control |
| io_hold_clr | input | 1 | Hold/clear modifier |
| io_ctl_clr | input | 1 | Clear bit of control/reset operations |
| io_bus_in | input | 16 | Host bus value into the card |
| io_bus_out | output | 16 | Host bus value returned |
| skip | output | 1 | Skip-next-instruction answer |
| cmd_flag_set | input | 1 | Command-flag set strobe from other blocks |
| cmd_flag_clr | input | 1 | Command-flag clear strobe from other blocks |
| dat_flag_set | input | 1 | Data-flag set strobe from other blocks |
| dat_flag_clr | input | 1 | Data-flag clear strobe from other blocks |
| xfer_start | input | 1 | Starts a data transfer |
| cmd_ctl | output | 1 | Command-channel control bit |
| cmd_flag | output | 1 | Command-channel flag |
| cmd_flag_buf | output | 1 | Command-channel flag buffer |
| cmd_srq | output | 1 | Command-channel service request |
| cmd_irq | output | 1 | Command-channel interrupt request |
| dat_flag | output | 1 | Data-channel flag |
| dat_flag_buf | output | 1 | Data-channel flag buffer |
| dat_srq | output | 1 | Data-channel service request |
| xfer_active | output | 1 | Data-transfer flip-flop |

## Verification
The assertions check the following on every cycle:
- The modifier clears the flag one edge later.
- A plain set-flag operation raises both flag and buffer.
- Command control follows the clear bit.
- Data-channel clears drop the transfer flip-flop.
- The holding register changes only on an output operation, and then takes the bus byte.
- The skip answer agrees with the command flag.

Only the bench's scenarios show the following:
- The reset state.
- The combinational bus values for load, merge and pass-through.
- The isolation between channels.
- The clear-wins ordering when external strobes and host operations collide.

// File: rtl/iochan_pkg.sv
package iochan_pkg;

    typedef enum logic [2:0] {
        OP_RESET    = 3'd0,
        OP_FLAG     = 3'd1,
        OP_SKIP_CLR = 3'd2,
        OP_SKIP_SET = 3'd3,
        OP_WRITE    = 3'd4,
        OP_MERGE    = 3'd5,
        OP_LOAD     = 3'd6,
        OP_CTRL     = 3'd7
    } io_op_e;

    // Encoding is {control, flag}
    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_FLAGGED = 2'b01,
        ST_ARMED   = 2'b10,
        ST_REQUEST = 2'b11
    } chan_state_e;

    localparam logic SEL_CMD = 1'b0;
    localparam logic SEL_DAT = 1'b1;

endpackage

// File: rtl/iochan_chan.sv
module iochan_chan
    import iochan_pkg::*;
#(
    parameter int HAS_CTL = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic [2:0] op,
    input  logic       hold_clr,
    input  logic       ctl_clr,
    input  logic       ext_set,
    input  logic       ext_clr,
    output logic       ctl,
    output logic       flag,
    output logic       flag_buf,
    output logic       srq,
    output logic       irq
);

    chan_state_e state_q, state_n;
    logic        fbuf_q;
    logic        set_req, clr_req, ctl_op, flag_n, ctl_n;
    io_op_e      op_e;

    assign op_e = io_op_e'(op);

    always_comb begin
        set_req = ext_set | (hit & (op_e == OP_FLAG) & ~hold_clr);
        clr_req = ext_clr | (hit & hold_clr);
        ctl_op  = hit & ((op_e == OP_CTRL) | (op_e == OP_RESET));
        flag_n  = clr_req ? 1'b0 : (set_req ? 1'b1 : flag);
        ctl_n   = ctl;
        if ((HAS_CTL != 0) && ctl_op) begin
            ctl_n = ~ctl_clr;
        end
        state_n = chan_state_e'({ctl_n, flag_n});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fbuf_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            fbuf_q  <= flag_n;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:    begin ctl = 1'b0; flag = 1'b0; irq = 1'b0; end
            ST_FLAGGED: begin ctl = 1'b0; flag = 1'b1; irq = 1'b0; end
            ST_ARMED:   begin ctl = 1'b1; flag = 1'b0; irq = 1'b0; end
            ST_REQUEST: begin ctl = 1'b1; flag = 1'b1; irq = 1'b1; end
            default:    begin ctl = 1'b0; flag = 1'b0; irq = 1'b0; end
        endcase
    end

    assign flag_buf = fbuf_q;
    assign srq      = flag;

    AST_MOD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && hold_clr) |=> (!flag && !flag_buf)); // R3

    AST_SET_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op_e == OP_FLAG && !hold_clr && !ext_clr) |=> (flag && flag_buf)); // R2

    AST_CTL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ((HAS_CTL != 0) && ctl_op) |=> (ctl == !$past(ctl_clr))); // R6

endmodule

// File: rtl/iochan_data.sv
module iochan_data
    import iochan_pkg::*;
#(
    parameter int BUS_W  = 16,
    parameter int HOLD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [2:0]       op,
    input  logic             ctl_clr,
    input  logic [BUS_W-1:0] bus_in,
    input  logic             xfer_start,
    output logic [BUS_W-1:0] bus_out,
    output logic             xfer_active
);

    localparam int PAD_W = BUS_W - HOLD_W;

    logic [HOLD_W-1:0] hold_q;
    logic [BUS_W-1:0]  hold_ext;
    logic              xfer_q, xfer_drop;
    io_op_e            op_e;

    assign op_e      = io_op_e'(op);
    assign hold_ext  = {{PAD_W{1'b0}}, hold_q};
    assign xfer_drop = hit & (((op_e == OP_CTRL) & ctl_clr) | (op_e == OP_RESET));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            xfer_q <= 1'b0;
        end else begin
            if (hit && op_e == OP_WRITE) begin
                hold_q <= bus_in[HOLD_W-1:0];
            end
            if (xfer_drop) begin
                xfer_q <= 1'b0;
            end else if (xfer_start) begin
                xfer_q <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_out = bus_in;
        if (hit) begin
            unique case (op_e)
                OP_LOAD:  bus_out = hold_ext;
                OP_MERGE: bus_out = bus_in | hold_ext;
                default:  bus_out = bus_in;
            endcase
        end
    end

    assign xfer_active = xfer_q;

    AST_XFER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_drop |=> !xfer_active); // R7

    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && op_e == OP_WRITE) |=> $stable(hold_q)); // R11

    AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op_e == OP_WRITE) |=> (hold_q == $past(bus_in[HOLD_W-1:0]))); // R8

endmodule

// File: rtl/iochan_flag_ctrl.sv
module iochan_flag_ctrl
    import iochan_pkg::*;
#(
    parameter int BUS_W  = 16,
    parameter int HOLD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_strobe,
    input  logic             io_sel,
    input  logic [2:0]       io_op,
    input  logic             io_hold_clr,
    input  logic             io_ctl_clr,
    input  logic [BUS_W-1:0] io_bus_in,
    output logic [BUS_W-1:0] io_bus_out,
    output logic             skip,
    input  logic             cmd_flag_set,
    input  logic             cmd_flag_clr,
    input  logic             dat_flag_set,
    input  logic             dat_flag_clr,
    input  logic             xfer_start,
    output logic             cmd_ctl,
    output logic             cmd_flag,
    output logic             cmd_flag_buf,
    output logic             cmd_srq,
    output logic             cmd_irq,
    output logic             dat_flag,
    output logic             dat_flag_buf,
    output logic             dat_srq,
    output logic             xfer_active
);

    logic   cmd_hit, dat_hit, sel_flag;
    logic   dat_ctl_unused, dat_irq_unused;
    io_op_e op_e;

    assign op_e    = io_op_e'(io_op);
    assign cmd_hit = io_strobe & (io_sel == SEL_CMD);
    assign dat_hit = io_strobe & (io_sel == SEL_DAT);

    iochan_chan #(.HAS_CTL(1)) u_cmd (
        .clk(clk), .rst_n(rst_n), .hit(cmd_hit), .op(io_op),
        .hold_clr(io_hold_clr), .ctl_clr(io_ctl_clr),
        .ext_set(cmd_flag_set), .ext_clr(cmd_flag_clr),
        .ctl(cmd_ctl), .flag(cmd_flag), .flag_buf(cmd_flag_buf),
        .srq(cmd_srq), .irq(cmd_irq)
    );

    iochan_chan #(.HAS_CTL(0)) u_dat (
        .clk(clk), .rst_n(rst_n), .hit(dat_hit), .op(io_op),
        .hold_clr(io_hold_clr), .ctl_clr(io_ctl_clr),
        .ext_set(dat_flag_set), .ext_clr(dat_flag_clr),
        .ctl(dat_ctl_unused), .flag(dat_flag), .flag_buf(dat_flag_buf),
        .srq(dat_srq), .irq(dat_irq_unused)
    );

    iochan_data #(.BUS_W(BUS_W), .HOLD_W(HOLD_W)) u_data (
        .clk(clk), .rst_n(rst_n), .hit(dat_hit), .op(io_op),
        .ctl_clr(io_ctl_clr), .bus_in(io_bus_in), .xfer_start(xfer_start),
        .bus_out(io_bus_out), .xfer_active(xfer_active)
    );

    assign sel_flag = io_sel ? dat_flag : cmd_flag;

    always_comb begin
        skip = 1'b0;
        if (io_strobe) begin
            unique case (op_e)
                OP_SKIP_CLR: skip = ~sel_flag;
                OP_SKIP_SET: skip = sel_flag;
                default:     skip = 1'b0;
            endcase
        end
    end

    AST_SKIP_SET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe && io_sel == SEL_CMD && op_e == OP_SKIP_SET && cmd_flag) |-> skip); // R4

    AST_SKIP_CLR_DAT: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe && io_sel == SEL_DAT && op_e == OP_SKIP_CLR) |-> (skip == !dat_flag)); // R4

endmodule

// File: tb/iochan_flag_ctrl_test.sv
module iochan_flag_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_strobe = 1'b0, io_sel = 1'b0, io_hold_clr = 1'b0, io_ctl_clr = 1'b0;
    logic [2:0]  io_op = 3'd0;
    logic [15:0] io_bus_in = 16'h0;
    logic [15:0] io_bus_out;
    logic        skip;
    logic        cmd_flag_set = 1'b0, cmd_flag_clr = 1'b0;
    logic        dat_flag_set = 1'b0, dat_flag_clr = 1'b0, xfer_start = 1'b0;
    logic        cmd_ctl, cmd_flag, cmd_flag_buf, cmd_srq, cmd_irq;
    logic        dat_flag, dat_flag_buf, dat_srq, xfer_active;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    iochan_flag_ctrl uut (
        .clk(clk), .rst_n(rst_n), .io_strobe(io_strobe), .io_sel(io_sel),
        .io_op(io_op), .io_hold_clr(io_hold_clr), .io_ctl_clr(io_ctl_clr),
        .io_bus_in(io_bus_in), .io_bus_out(io_bus_out), .skip(skip),
        .cmd_flag_set(cmd_flag_set), .cmd_flag_clr(cmd_flag_clr),
        .dat_flag_set(dat_flag_set), .dat_flag_clr(dat_flag_clr),
        .xfer_start(xfer_start), .cmd_ctl(cmd_ctl), .cmd_flag(cmd_flag),
        .cmd_flag_buf(cmd_flag_buf), .cmd_srq(cmd_srq), .cmd_irq(cmd_irq),
        .dat_flag(dat_flag), .dat_flag_buf(dat_flag_buf), .dat_srq(dat_srq),
        .xfer_active(xfer_active)
    );

    typedef struct packed {
        logic        sel;
        logic [2:0]  op;
        logic        hc;
        logic        cc;
        logic [15:0] din;
        logic        eskip;
        logic [15:0] ebus;
        logic        ecf;
        logic        edf;
        logic        ectl;
        logic        exf;
    } vec_t;

    // Starting state for the table: all flags 0, cmd_ctl 0, xfer_active 1
    localparam vec_t TBL [17] = '{
        '{1'b0, 3'd2, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 skip-if-clear
        '{1'b0, 3'd1, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1}, // R2 cmd set
        '{1'b0, 3'd3, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 skip-if-set
        '{1'b0, 3'd2, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 no skip
        '{1'b0, 3'd7, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1}, // R6 ctl set
        '{1'b1, 3'd1, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1}, // R3 set suppressed
        '{1'b1, 3'd1, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1}, // R2 dat set
        '{1'b1, 3'd4, 1'b0, 1'b0, 16'h12A5, 1'b0, 16'h12A5, 1'b1, 1'b1, 1'b1, 1'b1}, // R8 write
        '{1'b1, 3'd6, 1'b0, 1'b0, 16'hFFFF, 1'b0, 16'h00A5, 1'b1, 1'b1, 1'b1, 1'b1}, // R8 load
        '{1'b1, 3'd5, 1'b1, 1'b0, 16'h0F00, 1'b0, 16'h0FA5, 1'b1, 1'b0, 1'b1, 1'b1}, // R8 merge, R3 clear
        '{1'b1, 3'd7, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1}, // R7 ctl-set no effect
        '{1'b1, 3'd7, 1'b0, 1'b1, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 ctl-clear drops
        '{1'b0, 3'd3, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 + R3 modifier
        '{1'b0, 3'd0, 1'b0, 1'b1, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 reset clears ctl
        '{1'b0, 3'd4, 1'b0, 1'b0, 16'h00FF, 1'b0, 16'h00FF, 1'b0, 1'b0, 1'b0, 1'b0}, // R11 cmd output
        '{1'b1, 3'd6, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h00A5, 1'b0, 1'b0, 1'b0, 1'b0}, // R11 hold kept
        '{1'b0, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0}  // R6 reset sets ctl
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    task automatic host_op(input logic s, input logic [2:0] o, input logic hc,
                           input logic cc, input logic [15:0] d);
        @(negedge clk);
        io_strobe = 1'b1; io_sel = s; io_op = o;
        io_hold_clr = hc; io_ctl_clr = cc; io_bus_in = d;
    endtask

    task automatic idle_after_edge();
        @(posedge clk);
        #2;
    endtask

    task automatic release_host();
        io_strobe = 1'b0; io_hold_clr = 1'b0; io_ctl_clr = 1'b0; io_bus_in = 16'h0;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cmd_flag", {15'd0, cmd_flag}, 16'd0);
        chk("R1 cmd_flag_buf", {15'd0, cmd_flag_buf}, 16'd0);
        chk("R1 cmd_ctl", {15'd0, cmd_ctl}, 16'd0);
        chk("R1 cmd_irq", {15'd0, cmd_irq}, 16'd0);
        chk("R1 dat_flag", {15'd0, dat_flag}, 16'd0);
        chk("R1 srq", {14'd0, cmd_srq, dat_srq}, 16'd0);
        chk("R1 xfer", {15'd0, xfer_active}, 16'd0);
        rst_n = 1'b1;

        host_op(1'b1, 3'd6, 1'b0, 1'b0, 16'h0000);
        #2 chk("R1 hold reads 0", io_bus_out, 16'h0000);
        idle_after_edge();
        release_host();

        // R10 start transfer
        @(negedge clk); xfer_start = 1'b1;
        @(posedge clk); #2 xfer_start = 1'b0;
        chk("R10 xfer set", {15'd0, xfer_active}, 16'd1);

        foreach (TBL[i]) begin
            host_op(TBL[i].sel, TBL[i].op, TBL[i].hc, TBL[i].cc, TBL[i].din);
            #2;
            chk($sformatf("R4 skip step %0d", i), {15'd0, skip}, {15'd0, TBL[i].eskip});
            chk($sformatf("R8/R11 bus step %0d", i), io_bus_out, TBL[i].ebus);
            idle_after_edge();
            release_host();
            chk($sformatf("R2/R3 cmd_flag step %0d", i), {15'd0, cmd_flag}, {15'd0, TBL[i].ecf});
            chk($sformatf("R2/R3 cmd_flag_buf step %0d", i), {15'd0, cmd_flag_buf}, {15'd0, TBL[i].ecf});
            chk($sformatf("R2/R3 dat_flag step %0d", i), {14'd0, dat_flag, dat_flag_buf}, {14'd0, TBL[i].edf, TBL[i].edf});
            chk($sformatf("R6 cmd_ctl step %0d", i), {15'd0, cmd_ctl}, {15'd0, TBL[i].ectl});
            chk($sformatf("R7 xfer step %0d", i), {15'd0, xfer_active}, {15'd0, TBL[i].exf});
            chk($sformatf("R5 srq step %0d", i), {14'd0, cmd_srq, dat_srq}, {14'd0, TBL[i].ecf, TBL[i].edf});
            chk($sformatf("R5 irq step %0d", i), {15'd0, cmd_irq}, {15'd0, TBL[i].ecf & TBL[i].ectl});
        end

        // R9 external set on command channel (cmd_ctl is 1 here)
        @(negedge clk); cmd_flag_set = 1'b1;
        @(posedge clk); #2 cmd_flag_set = 1'b0;
        chk("R9 cmd ext set", {14'd0, cmd_flag, cmd_flag_buf}, 16'd3);
        chk("R5 irq with ctl and flag", {15'd0, cmd_irq}, 16'd1);

        // R9 set and clear collide on data channel
        @(negedge clk); dat_flag_set = 1'b1; dat_flag_clr = 1'b1;
        @(posedge clk); #2 dat_flag_set = 1'b0; dat_flag_clr = 1'b0;
        chk("R9 clear wins", {14'd0, dat_flag, dat_flag_buf}, 16'd0);

        // R9 external clear on command channel
        @(negedge clk); cmd_flag_clr = 1'b1;
        @(posedge clk); #2 cmd_flag_clr = 1'b0;
        chk("R9 cmd ext clear", {14'd0, cmd_flag, cmd_flag_buf}, 16'd0);

        // R10 start collides with data control-clear
        host_op(1'b1, 3'd7, 1'b0, 1'b1, 16'h0000);
        xfer_start = 1'b1;
        idle_after_edge();
        xfer_start = 1'b0;
        release_host();
        chk("R10 drop wins", {15'd0, xfer_active}, 16'd0);

        // R7 data reset op drops transfer even without clear bit
        @(negedge clk); xfer_start = 1'b1;
        @(posedge clk); #2 xfer_start = 1'b0;
        host_op(1'b1, 3'd0, 1'b0, 1'b0, 16'h0000);
        idle_after_edge();
        release_host();
        chk("R7 reset op drops xfer", {15'd0, xfer_active}, 16'd0);
        chk("R7 dat flag untouched", {15'd0, dat_flag}, 16'd0);

        // R1 reset mid-operation
        host_op(1'b0, 3'd1, 1'b0, 1'b0, 16'h0000);
        idle_after_edge();
        release_host();
        @(negedge clk); rst_n = 1'b0;
        #2;
        chk("R1 flags after reset", {13'd0, cmd_flag, cmd_ctl, cmd_irq}, 16'd0);
        @(negedge clk); rst_n = 1'b1;
        host_op(1'b1, 3'd6, 1'b0, 1'b0, 16'h0000);
        #2 chk("R1 hold cleared", io_bus_out, 16'h0000);
        idle_after_edge();
        release_host();

        finish_run();
    end

endmodule